// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM

A small synchronous static RAM that accepts a new read or write command on every rising clock edge and never needs idle cycles when the bus direction changes. It stores 64 words of 36 bits, organised as four 9-bit byte lanes. Every command input is registered on the rising edge. Write data arrives later than its address: two edges later in pipelined mode and one edge later in flow-through mode. Because of this, a read can follow a write, and a write can follow a read, with no dead cycle between them.

A static mode input selects one of two read timings. In pipelined mode read data passes through an output register. In flow-through mode read data is driven in the cycle right after the address edge. A 2-bit burst counter produces the following beat addresses from an advance input. It steps the two low address bits in either linear or interleaved order. Three chip enables must all be high to start an access. An asynchronous output enable and an asynchronous sleep input can blank the output at any time. The tri-state data bus is modelled as a data bus plus a valid flag.

Top module: `zt_sram`

## Requirements
- R1: A new access starts at a rising edge only when ce0_i, ce1_i and ce2_i are all 1 and adv_i is 0. With adv_i at 0 and any chip enable at 0, the cycle is a deselect: no write happens, no read data is driven, and any open burst ends.
- R2: With pipe_mode_i=1, a read whose address is sampled at edge k drives its word with rvalid_o=1 between edge k+1 and edge k+2.
- R3: With pipe_mode_i=0, a read sampled at edge k drives its word with rvalid_o=1 between edge k and edge k+1.
- R4: Write data for a write sampled at edge k is taken from wdata_i at edge k+2 when pipe_mode_i=1, and at edge k+1 when pipe_mode_i=0.
- R5: byte_en_i is sampled with the write address. Bit j of byte_en_i enables lane j, which is wdata_i bits [9j+8:9j]. Disabled lanes keep their stored value.
- R6: A read issued on the edge right after a write to the same address returns the merged new data. In pipelined mode this data is forwarded from the pending write stage.
- R7: Reads and writes may alternate on every edge with no idle cycle, and every access completes correctly.
- R8: While a burst is open, adv_i=1 issues the next beat with the same direction as the first beat; the chip enables and we_i are ignored. For beat n (n counts modulo 4, starting at 0 on the first beat), the two low address bits are base+n modulo 4 when burst_ilv_i=0, and base XOR n when burst_ilv_i=1. The upper address bits stay fixed. adv_i=1 with no open burst is a deselect.
- R9: oe_i=0 forces rvalid_o to 0 and rdata_o to zero at once, without waiting for a clock edge. It does not change stored data or the reads in flight.
- R10: sleep_i=1 forces rvalid_o to 0 and rdata_o to zero at once. A command sampled while sleep_i=1 is ignored and closes any open burst.
- R11: After reset no read data is driven and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | Static mode: 1 pipelined, 0 flow-through |
| burst_ilv_i | input | 1 | Static burst order: 1 interleaved, 0 linear |
| ce0_i | input | 1 | Chip enable 0, active high |
| ce1_i | input | 1 | Chip enable 1, active high |
| ce2_i | input | 1 | Chip enable 2, active high |
| adv_i | input | 1 | Advance to the next burst beat |
| we_i | input | 1 | 1 write, 0 read (first beat only) |
| addr_i | input | 6 | Word address |
| byte_en_i | input | 4 | Byte lane write enables |
| wdata_i | input | 36 | Late write data |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep |
| rdata_o | output | 36 | Read data, zero when not driven |
| rvalid_o | output | 1 | Read data is being driven |

## Verification
On every cycle, the assertions check the following:
- the read latency in each mode, measured from the accepted command to the driven flag;
- the silence that follows a deselect;
- the blanking caused by output enable and sleep;
- the one- or two-edge delay between a write command and its array commit;
- that burst beats keep their page and direction.

Data correctness needs the bench's scenarios. These scenarios include:
- byte-lane merging;
- forwarding from a pending write to an immediate read;
- alternating read and write traffic;
- the exact linear and interleaved beat order;
- ignored writes under deselect or sleep, each followed by a read of the word the ignored write could have changed.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int BURST_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // low address bits of a burst beat
  function automatic logic [BURST_W-1:0] beat_low(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] cnt,
    input burst_ord_e         ord
  );
    return (ord == ORD_INTERLEAVE) ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ilv_i,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic              we_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_v_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  import zt_pkg::*;
  localparam int BW = BURST_W;

  logic              act_q, wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [BW-1:0]     cnt_q, cnt_nx;
  logic              start, cont;
  burst_ord_e        ord;

  assign ord    = ilv_i ? ORD_INTERLEAVE : ORD_LINEAR;
  assign start  = ~sleep_i & sel_i & ~adv_i;
  assign cont   = ~sleep_i & adv_i & act_q;
  assign cnt_nx = cnt_q + BW'(1);

  always_comb begin
    cmd_v_o    = start | cont;
    cmd_we_o   = start ? we_i : wr_q;
    cmd_addr_o = start ? addr_i
                       : {base_q[ADDR_W-1:BW], beat_low(base_q[BW-1:0], cnt_nx, ord)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q <= start | cont;
      if (start) begin
        wr_q   <= we_i;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (cont) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  p_burst_page_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont |-> (cmd_addr_o[ADDR_W-1:BW] == $past(cmd_addr_o[ADDR_W-1:BW]))
             && (cmd_we_o == $past(cmd_we_o)));

  p_sleep_close_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !act_q);
endmodule

// File: rtl/zt_late_write.sv
module zt_late_write #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              cmd_v_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LANES-1:0]  cmd_be_i,
  output logic              com_v_o,
  output logic [ADDR_W-1:0] com_addr_o,
  output logic [LANES-1:0]  com_be_o
);
  localparam int STAGES = 2;
  localparam int FT_IDX = 0;
  localparam int PL_IDX = STAGES - 1;

  logic [STAGES-1:0] v_q;
  logic [ADDR_W-1:0] a_q [STAGES];
  logic [LANES-1:0]  b_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < STAGES; i++) begin
        a_q[i] <= '0;
        b_q[i] <= '0;
      end
    end else begin
      v_q[0] <= cmd_v_i;
      a_q[0] <= cmd_addr_i;
      b_q[0] <= cmd_be_i;
      for (int i = 1; i < STAGES; i++) begin
        v_q[i] <= v_q[i-1];
        a_q[i] <= a_q[i-1];
        b_q[i] <= b_q[i-1];
      end
    end
  end

  assign com_v_o    = pipe_mode_i ? v_q[PL_IDX] : v_q[FT_IDX];
  assign com_addr_o = pipe_mode_i ? a_q[PL_IDX] : a_q[FT_IDX];
  assign com_be_o   = pipe_mode_i ? b_q[PL_IDX] : b_q[FT_IDX];

  p_commit_pipe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_mode_i && cmd_v_i |=> ##1 com_v_o);

  p_commit_flow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pipe_mode_i && cmd_v_i |=> com_v_o && com_addr_o == $past(cmd_addr_i));
endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int g = 0; g < LANES; g++) begin
        if (be_i[g]) mem[waddr_i][g*LANE_W +: LANE_W] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/zt_read_path.sv
module zt_read_path #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    rd_v_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic [LANES*LANE_W-1:0] arr_data_i,
  input  logic                    com_v_i,
  input  logic [ADDR_W-1:0]       com_addr_i,
  input  logic [LANES-1:0]        com_be_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              hit, ov_q, data_v, drive;
  logic [DATA_W-1:0] merged, od_q, data;

  // forward the write committing on this edge into the output register
  assign hit = com_v_i && (com_addr_i == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (hit && com_be_i[g]) ? wdata_i[g*LANE_W +: LANE_W]
                                                              : arr_data_i[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= rd_v_i;
      if (rd_v_i) od_q <= merged;
    end
  end

  assign data_v   = pipe_mode_i ? ov_q : rd_v_i;
  assign data     = pipe_mode_i ? od_q : arr_data_i;
  assign drive    = data_v & oe_i & ~sleep_i;
  assign rvalid_o = drive;
  assign rdata_o  = drive ? data : '0;

  p_oe_blank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !rvalid_o && rdata_o == '0);

  p_sleep_blank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !rvalid_o && rdata_o == '0);
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    burst_ilv_i,
  input  logic                    ce0_i,
  input  logic                    ce1_i,
  input  logic                    ce2_i,
  input  logic                    adv_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        byte_en_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              sel, cmd_v, cmd_we;
  logic [ADDR_W-1:0] cmd_addr;
  logic              rd_v_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              com_v;
  logic [ADDR_W-1:0] com_addr;
  logic [LANES-1:0]  com_be;
  logic [DATA_W-1:0] arr_data;

  assign sel = ce0_i & ce1_i & ce2_i;

  zt_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i, .rst_ni,
    .ilv_i      (burst_ilv_i),
    .sel_i      (sel),
    .adv_i, .we_i, .sleep_i, .addr_i,
    .cmd_v_o    (cmd_v),
    .cmd_we_o   (cmd_we),
    .cmd_addr_o (cmd_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q    <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_v_q <= cmd_v & ~cmd_we;
      if (cmd_v & ~cmd_we) rd_addr_q <= cmd_addr;
    end
  end

  zt_late_write #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wpipe (
    .clk_i, .rst_ni, .pipe_mode_i,
    .cmd_v_i    (cmd_v & cmd_we),
    .cmd_addr_i (cmd_addr),
    .cmd_be_i   (byte_en_i),
    .com_v_o    (com_v),
    .com_addr_o (com_addr),
    .com_be_o   (com_be)
  );

  zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i,
    .we_i    (com_v),
    .waddr_i (com_addr),
    .be_i    (com_be),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr_q),
    .rdata_o (arr_data)
  );

  zt_read_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rpath (
    .clk_i, .rst_ni, .pipe_mode_i,
    .rd_v_i     (rd_v_q),
    .rd_addr_i  (rd_addr_q),
    .arr_data_i (arr_data),
    .com_v_i    (com_v),
    .com_addr_i (com_addr),
    .com_be_i   (com_be),
    .wdata_i, .oe_i, .sleep_i, .rdata_o, .rvalid_o
  );

  p_pipe_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_mode_i && cmd_v && !cmd_we |=> ##1 (rvalid_o == (oe_i && !sleep_i)));

  p_flow_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pipe_mode_i && cmd_v && !cmd_we |=> (rvalid_o == (oe_i && !sleep_i)));

  p_desel_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pipe_mode_i && !sel && !adv_i |=> !rvalid_o);
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          pipe_mode_i = 1'b1, burst_ilv_i = 1'b0;
  logic          ce0_i = 1'b0, ce1_i = 1'b0, ce2_i = 1'b0;
  logic          adv_i = 1'b0, we_i = 1'b0, oe_i = 1'b1, sleep_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [LN-1:0] byte_en_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  zt_sram u0 (.*);

  always #4 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int total = 0, bad = 0;

  typedef struct {
    int            due;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t          sb[$];
  exp_t          it;
  logic [DW-1:0] ref_mem [64];
  logic [DW-1:0] sched [int];
  bit            b_act, b_we;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  task automatic chk(input string req, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected reads when due, flag any other driven data
  always @(negedge clk_i) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      if (oe_i && !sleep_i)
        chk(it.req, rvalid_o === 1'b1 && rdata_o === it.data, rdata_o, it.data);
      else
        chk(it.req, rvalid_o === 1'b0 && rdata_o === '0, rdata_o, '0);
    end else if (rst_ni && rvalid_o !== 1'b0) begin
      chk("R1 unexpected drive", 1'b0, rdata_o, '0);
    end
  end

  // drive one command for the next edge; model expected results
  task automatic issue(input bit [2:0] ce, input bit adv, input bit we, input logic [AW-1:0] a,
                       input logic [LN-1:0] be, input logic [DW-1:0] wd, input string req,
                       input bit oe = 1'b1, input bit slp = 1'b0);
    int e, lat, dly;
    bit st, ct, wr;
    logic [AW-1:0] ea;
    logic [1:0] lo;
    e   = cyc + 1;
    lat = pipe_mode_i ? 1 : 0;
    dly = pipe_mode_i ? 2 : 1;
    ce0_i = ce[0]; ce1_i = ce[1]; ce2_i = ce[2];
    adv_i = adv; we_i = we; addr_i = a; byte_en_i = be; oe_i = oe; sleep_i = slp;
    wdata_i = sched.exists(e) ? sched[e] : (36'hA5A5A5A5A ^ DW'(e));
    st = !slp && (&ce) && !adv;
    ct = !slp && adv && b_act;
    wr = 1'b0;
    ea = a;
    if (st) begin
      b_act = 1'b1; b_we = we; b_base = a; b_cnt = 2'd0; wr = we;
    end else if (ct) begin
      b_cnt++;
      lo = burst_ilv_i ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
      ea = {b_base[AW-1:2], lo};
      wr = b_we;
    end else begin
      b_act = 1'b0;
    end
    if (st || ct) begin
      if (wr) begin
        for (int l = 0; l < LN; l++)
          if (be[l]) ref_mem[ea][l*LW +: LW] = wd[l*LW +: LW];
        sched[e + dly] = wd;
      end else begin
        sb.push_back('{due: e + lat, data: ref_mem[ea], req: req});
      end
    end
    @(posedge clk_i); #1;
  endtask

  task automatic idle(input int n, input bit oe = 1'b1, input bit slp = 1'b0);
    for (int i = 0; i < n; i++) issue(3'b000, 1'b0, 1'b0, '0, '0, '0, "idle", oe, slp);
  endtask

  task automatic do_reset(input bit pm, input bit ilv);
    rst_ni = 1'b0;
    pipe_mode_i = pm;
    burst_ilv_i = ilv;
    sb.delete();
    sched.delete();
    b_act = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R11 reset no drive", rvalid_o === 1'b0 && rdata_o === '0, rdata_o, '0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
  endtask

  task automatic run_mode(input bit pm, input bit ilv);
    string rq;
    rq = pm ? "R2" : "R3";
    do_reset(pm, ilv);
    // R4: full-word writes then reads
    for (int i = 0; i < 4; i++) issue(3'b111, 0, 1, AW'(8 + i), 4'hF, 36'h123456789 + DW'(i * 36'h111), "R4");
    for (int i = 0; i < 4; i++) issue(3'b111, 0, 0, AW'(8 + i), '0, '0, {rq, " R4 read"});
    // R5: byte lanes 0 and 2 only
    issue(3'b111, 0, 1, AW'(8), 4'b0101, 36'h0_0000_0000, "R5");
    idle(2);
    issue(3'b111, 0, 0, AW'(8), '0, '0, "R5 lanes");
    // R6: read right after write, full and partial
    issue(3'b111, 0, 1, AW'(20), 4'hF, 36'hABCDEF012, "R6");
    issue(3'b111, 0, 0, AW'(20), '0, '0, "R6 full");
    issue(3'b111, 0, 1, AW'(21), 4'hF, 36'h111111111, "R6");
    issue(3'b111, 0, 1, AW'(21), 4'b0011, 36'hFFFFFFFFF, "R6");
    issue(3'b111, 0, 0, AW'(21), '0, '0, "R6 partial");
    // R7: alternate every edge
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) issue(3'b111, 0, 1, AW'(30 + i), 4'hF, 36'h500000000 + DW'(i), "R7");
      else            issue(3'b111, 0, 0, AW'(30 + i - 1), '0, '0, "R7 alt");
    end
    issue(3'b111, 0, 0, AW'(30), '0, '0, "R7 old");
    // R8: burst write from 0x2E, burst read from 0x2D
    issue(3'b111, 0, 1, 6'h2E, 4'hF, 36'h0A0000001, "R8");
    for (int i = 1; i < 4; i++) issue(3'b000, 1, 0, '0, 4'hF, 36'h0A0000001 + DW'(i << 8), "R8");
    issue(3'b111, 0, 0, 6'h2D, '0, '0, "R8 beat");
    for (int i = 1; i < 4; i++) issue(3'b000, 1, 1, '0, '0, '0, "R8 beat");
    idle(1);
    issue(3'b000, 1, 0, 6'h2D, '0, '0, "R8 adv no burst");
    idle(2);
    // R1: each chip enable low blocks a write and a read
    for (int k = 0; k < 3; k++) begin
      issue(3'b111 & ~(3'b001 << k), 0, 1, AW'(9), 4'hF, 36'hDEADBEEF0, "R1");
      issue(3'b111 & ~(3'b001 << k), 0, 0, AW'(9), '0, '0, "R1");
    end
    idle(2);
    issue(3'b111, 0, 0, AW'(9), '0, '0, "R1 kept");
    idle(2);
    // R9: output enable low over the data window
    issue(3'b111, 0, 0, AW'(10), '0, '0, "R9 blank");
    idle(2, 1'b0);
    issue(3'b111, 0, 0, AW'(10), '0, '0, "R9 after");
    idle(2);
    // R10: sleep blanks, blocks commands, closes burst
    issue(3'b111, 0, 0, AW'(11), '0, '0, "R10 blank");
    idle(2, 1'b1, 1'b1);
    issue(3'b111, 0, 1, AW'(11), 4'hF, 36'h0F0F0F0F0, "R10", 1'b1, 1'b1);
    issue(3'b111, 0, 0, AW'(11), '0, '0, "R10", 1'b1, 1'b1);
    idle(2);
    issue(3'b111, 0, 0, AW'(11), '0, '0, "R10 kept");
    issue(3'b111, 0, 0, 6'h2C, '0, '0, "R10 burst");
    issue(3'b000, 1, 0, '0, '0, '0, "R10", 1'b1, 1'b1);
    issue(3'b000, 1, 0, '0, '0, '0, "R10 closed");
    idle(4);
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    run_mode(1'b1, 1'b0);
    run_mode(1'b0, 1'b0);
    run_mode(1'b1, 1'b1);
    run_mode(1'b0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule